// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Engine

This block is the bus-facing protocol engine of a small serial EEPROM that sits on an I2C bus as a slave. It oversamples the SCL and SDA lines with the system clock and recognises START and STOP conditions. It shifts in a device byte, a word address and data bytes, and it answers on SDA through an open-drain output enable. Accepted write bytes go to a memory-side page buffer one by one, and a separate pulse at the closing STOP tells the memory side to begin its program cycle. Read transfers fetch bytes through a plain address/data port and shift them out MSB first.

The memory side reports a running program cycle on `busy_i`. While that input is high the engine refuses its own device byte, so a master can poll for the acknowledge to learn when the array is free again. A write-protect input guards the upper half of the 2 KiB array. Protected writes are still acknowledged through the word address, but the first data byte is refused and nothing is committed.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A device byte whose upper four bits are 1010 is acknowledged by holding SDA low for the ninth SCL pulse. Its bits [3:1] select the block and form byte-address bits [10:8], and bit 0 selects read (1) or write (0).
- R2: While `busy_i` is high when the device byte completes, that byte gets no acknowledge and the rest of the transfer is ignored.
- R3: In a write, the word address byte and every data byte are acknowledged. Each data byte produces one `wr_byte_o` pulse, with `wr_addr_o` = {block, byte address} and `wr_data_o` = the byte.
- R4: Successive data bytes of one write advance only address bits [3:0], wrapping inside the 16-byte page. Bits [10:4] are kept.
- R5: `wr_commit_o` pulses once at a STOP that follows at least one accepted data byte. A STOP with no accepted data byte gives no pulse, and a repeated START throws away the accepted bytes it follows.
- R6: With `wp_i` high, a write whose address has bit 10 set still gets acknowledges for the device and word address bytes. The first data byte gets no acknowledge, no `wr_byte_o`, and no commit. With `wp_i` low the upper half is written normally.
- R7: In a read, each byte is taken from `rd_data_i` at `rd_addr_o` and sent MSB first. After each byte the address advances across all 11 bits. A master acknowledge continues the read, and a master non-acknowledge ends it.
- R8: A START or STOP in the middle of a byte abandons the transfer and clears the bit count, so the next transfer is handled normally.
- R9: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. `sda_oe_o` changes only after a falling SCL edge or at START/STOP, and it is never set while the master is sending bits.
- R10: A device byte whose upper four bits differ from 1010 is not acknowledged, and no write results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| busy_i | input | 1 | Memory-side program cycle running |
| wp_i | input | 1 | Write protect for the upper half |
| wr_byte_o | output | 1 | One-cycle pulse: data byte accepted |
| wr_addr_o | output | 11 | Byte address of the accepted byte |
| wr_data_o | output | 8 | Accepted data byte |
| wr_commit_o | output | 1 | One-cycle pulse: start program cycle |
| rd_addr_o | output | 11 | Byte address for read data |
| rd_data_i | input | 8 | Read data at `rd_addr_o` |

## Verification
The bound checker checks on every cycle that the output enable moves only after an SCL fall or a bus condition and stays off while data bits arrive. It also checks that a commit comes only right after a STOP, that no byte is handed over for a protected address, and that consecutive handed-over addresses stay in one page and step by one modulo 16. The bench scenarios cover what needs a whole transaction: acknowledge polling against `busy_i`, device-code mismatch, refused protected data followed by a missing commit, and discarding on repeated START. They also cover read data order and carry across a block boundary, and recovery after aborted bytes.

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter int BLK_W = 3,
  parameter int PAGE_W = 4,
  parameter logic [6-BLK_W:0] DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              busy_i,
  input  logic              wp_i,
  output logic              wr_byte_o,
  output logic [BLK_W+7:0]  wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o,
  output logic [BLK_W+7:0]  rd_addr_o,
  input  logic [7:0]        rd_data_i
);
  localparam int AW = BLK_W + 8;
  localparam int DW = 7 - BLK_W;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WADR, S_WDAT, S_RDAT, S_HOLD} state_t;

  logic [2:0] scl_sy, sda_sy;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 3'b111;
      sda_sy <= 3'b111;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end

  logic scl_s, scl_q, sda_s, sda_q;
  assign scl_s = scl_sy[1];
  assign scl_q = scl_sy[2];
  assign sda_s = sda_sy[1];
  assign sda_q = sda_sy[2];

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  state_t            state;
  logic [3:0]        cnt;
  logic [7:0]        sr, tx;
  logic [AW-1:0]     addr;
  logic [BLK_W-1:0]  blk;
  logic              rw, pend;

  logic [7:0]        nb;
  logic              dev_hit, in_rx;
  logic [PAGE_W-1:0] pg_nxt;
  assign nb      = {sr[6:0], sda_s};
  assign dev_hit = nb[7:8-DW] == DEV_CODE;
  assign in_rx   = state == S_DEV || state == S_WADR || state == S_WDAT;
  assign pg_nxt  = addr[PAGE_W-1:0] + PAGE_W'(1);
  assign rd_addr_o = addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      sr          <= '0;
      tx          <= '0;
      addr        <= '0;
      blk         <= '0;
      rw          <= 1'b0;
      pend        <= 1'b0;
      sda_oe_o    <= 1'b0;
      wr_byte_o   <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      wr_commit_o <= 1'b0;
    end else begin
      wr_byte_o   <= 1'b0;
      wr_commit_o <= 1'b0;
      if (start_c) begin
        state    <= S_DEV;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
        pend     <= 1'b0;
      end else if (stop_c) begin
        state       <= S_IDLE;
        cnt         <= '0;
        sda_oe_o    <= 1'b0;
        wr_commit_o <= pend;
        pend        <= 1'b0;
      end else if (state != S_IDLE && state != S_HOLD) begin
        if (scl_rise) begin
          cnt <= cnt + 4'd1;
          if (cnt < 4'd8 && in_rx) sr <= nb;
          if (cnt == 4'd7 && in_rx) begin
            case (state)
              S_DEV:
                if (dev_hit && !busy_i) begin
                  blk <= nb[BLK_W:1];
                  rw  <= nb[0];
                  if (nb[0]) addr[AW-1:8] <= nb[BLK_W:1];
                end else begin
                  state <= S_HOLD;
                end
              S_WADR: addr <= {blk, nb};
              S_WDAT:
                if (wp_i && addr[AW-1]) begin
                  state <= S_HOLD;
                end else begin
                  wr_byte_o             <= 1'b1;
                  wr_addr_o             <= addr;
                  wr_data_o             <= nb;
                  addr[PAGE_W-1:0]      <= pg_nxt;
                  pend                  <= 1'b1;
                end
              default: ;
            endcase
          end
          if (cnt == 4'd8 && state == S_RDAT) begin
            addr <= addr + AW'(1);
            if (sda_s) state <= S_HOLD;
          end
        end else if (scl_fall) begin
          if (cnt == 4'd8) begin
            sda_oe_o <= state != S_RDAT;
          end else if (cnt == 4'd9) begin
            cnt <= '0;
            if (state == S_RDAT || (state == S_DEV && rw)) begin
              state    <= S_RDAT;
              tx       <= {rd_data_i[6:0], 1'b0};
              sda_oe_o <= ~rd_data_i[7];
            end else begin
              sda_oe_o <= 1'b0;
              state    <= (state == S_DEV) ? S_WADR : S_WDAT;
            end
          end else if (state == S_RDAT) begin
            sda_oe_o <= ~tx[7];
            tx       <= {tx[6:0], 1'b0};
          end
        end
      end
    end
endmodule

// File: rtl/eeprom_i2c_slave_chk.sv
module eeprom_i2c_slave_chk #(
  parameter int AW = 11,
  parameter int PAGE_W = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_fall,
  input logic          start_c,
  input logic          stop_c,
  input logic          sda_oe_o,
  input logic          wp_i,
  input logic          wr_byte_o,
  input logic [AW-1:0] wr_addr_o,
  input logic          wr_commit_o
);
  logic          have_prev;
  logic [AW-1:0] last;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      have_prev <= 1'b0;
      last      <= '0;
    end else if (start_c || stop_c) begin
      have_prev <= 1'b0;
    end else if (wr_byte_o) begin
      have_prev <= 1'b1;
      last      <= wr_addr_o;
    end

  assert_page_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte_o && have_prev |-> wr_addr_o[AW-1:PAGE_W] == last[AW-1:PAGE_W] &&
                               wr_addr_o[PAGE_W-1:0] == last[PAGE_W-1:0] + PAGE_W'(1));

  assert_commit_at_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |-> $past(stop_c));

  assert_protected_no_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte_o |-> !($past(wp_i) && wr_addr_o[AW-1]));

  assert_oe_rise_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> $past(scl_fall));

  assert_oe_fall_on_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_o) |-> $past(scl_fall || start_c || stop_c));

  assert_quiet_while_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte_o |-> !sda_oe_o);
endmodule

bind eeprom_i2c_slave eeprom_i2c_slave_chk #(.AW(AW), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c),
  .sda_oe_o(sda_oe_o), .wp_i(wp_i), .wr_byte_o(wr_byte_o), .wr_addr_o(wr_addr_o),
  .wr_commit_o(wr_commit_o)
);

// File: tb/test_eeprom_i2c_slave.sv
module test_eeprom_i2c_slave;
  localparam int H = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, busy = 1'b0, wp = 1'b0;
  logic sda_oe, wr_byte, wr_commit;
  logic [10:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;
  assign rd_data = rd_addr[7:0] ^ {rd_addr[10:8], 5'h15};

  eeprom_i2c_slave i_eeprom_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .busy_i(busy), .wp_i(wp), .wr_byte_o(wr_byte), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .wr_commit_o(wr_commit), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  int n_chk = 0, n_err = 0, n_bytes = 0, n_commit = 0;
  logic [10:0] log_a [0:63];
  logic [7:0]  log_d [0:63];

  always @(posedge clk) begin
    if (wr_byte) begin
      log_a[n_bytes[5:0]] <= wr_addr;
      log_d[n_bytes[5:0]] <= wr_data;
      n_bytes <= n_bytes + 1;
    end
    if (wr_commit) n_commit <= n_commit + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic hc(); repeat (H) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; hc(); scl = 1'b1; hc(); sda_m = 1'b0; hc(); scl = 1'b0; hc();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hc(); scl = 1'b1; hc(); sda_m = 1'b1; hc(); hc();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hc(); scl = 1'b1; hc(); scl = 1'b0; repeat (2) @(negedge clk);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; hc(); scl = 1'b1;
    repeat (H/2) @(negedge clk);
    ack = !sda_line;
    repeat (H/2) @(negedge clk);
    scl = 1'b0; repeat (2) @(negedge clk);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hc(); scl = 1'b1;
      repeat (H/2) @(negedge clk);
      b[i] = sda_line;
      repeat (H/2) @(negedge clk);
      scl = 1'b0; repeat (2) @(negedge clk);
    end
    sda_m = !mack; hc(); scl = 1'b1; hc(); scl = 1'b0; repeat (2) @(negedge clk);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] dev(input int blk, input bit rd);
    return {4'b1010, blk[2:0], rd};
  endfunction

  function automatic logic [7:0] pat(input logic [10:0] a);
    return a[7:0] ^ {a[10:8], 5'h15};
  endfunction

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R9 reset oe", sda_oe, 0);
    chk(n_bytes == 0 && n_commit == 0, "R5 reset no write", n_bytes + n_commit, 0);
  endtask

  task automatic t_byte_write();
    bit a; int nb0 = n_bytes, nc0 = n_commit;
    bus_start();
    send_byte(dev(1, 0), a); chk(a, "R1 device ack", a, 1);
    send_byte(8'h23, a);     chk(a, "R3 word addr ack", a, 1);
    send_byte(8'h5A, a);     chk(a, "R3 data ack", a, 1);
    chk(n_bytes == nb0 + 1, "R3 byte pulse", n_bytes - nb0, 1);
    chk(log_a[nb0] == 11'h123, "R3 byte addr", log_a[nb0], 'h123);
    chk(log_d[nb0] == 8'h5A, "R3 byte data", log_d[nb0], 'h5A);
    chk(n_commit == nc0, "R5 no commit before stop", n_commit - nc0, 0);
    bus_stop();
    chk(n_commit == nc0 + 1, "R5 commit at stop", n_commit - nc0, 1);
  endtask

  task automatic t_busy_poll();
    bit a; int nc0 = n_commit;
    busy = 1'b1;
    bus_start(); send_byte(dev(0, 0), a); bus_stop();
    chk(!a, "R2 busy nack", a, 0);
    busy = 1'b0;
    bus_start(); send_byte(dev(0, 0), a);
    chk(a, "R2 ack after busy", a, 1);
    send_byte(8'h10, a); bus_stop();
    chk(n_commit == nc0, "R5 stop before data no commit", n_commit - nc0, 0);
  endtask

  task automatic t_wrong_code();
    bit a; int nb0 = n_bytes;
    bus_start(); send_byte(8'hB2, a);
    chk(!a, "R10 foreign code nack", a, 0);
    send_byte(8'h00, a); send_byte(8'h77, a); bus_stop();
    chk(n_bytes == nb0, "R10 no byte", n_bytes - nb0, 0);
  endtask

  task automatic t_page();
    bit a; bit all_ack = 1'b1; int nb0 = n_bytes, nc0 = n_commit;
    bus_start(); send_byte(dev(2, 0), a); send_byte(8'h0E, a);
    for (int k = 0; k < 18; k++) begin
      send_byte(8'h40 + 8'(k), a);
      all_ack &= a;
    end
    chk(all_ack, "R3 all page bytes acked", all_ack, 1);
    chk(log_a[nb0] == 11'h20E, "R4 first addr", log_a[nb0], 'h20E);
    chk(log_a[nb0 + 2] == 11'h200, "R4 wrap addr", log_a[nb0 + 2], 'h200);
    chk(log_a[nb0 + 17] == 11'h20F, "R4 last addr", log_a[nb0 + 17], 'h20F);
    chk(log_d[nb0 + 17] == 8'h51, "R4 last data", log_d[nb0 + 17], 'h51);
    bus_stop();
    chk(n_commit == nc0 + 1, "R5 page commit", n_commit - nc0, 1);
  endtask

  task automatic t_protect();
    bit a1, a2, a3; int nb0 = n_bytes, nc0 = n_commit;
    wp = 1'b1;
    bus_start(); send_byte(dev(4, 0), a1); send_byte(8'h31, a2); send_byte(8'hC3, a3); bus_stop();
    chk(a1 && a2, "R6 protected addr acks", {a1, a2}, 3);
    chk(!a3, "R6 protected data nack", a3, 0);
    chk(n_bytes == nb0 && n_commit == nc0, "R6 no write no commit", n_bytes - nb0 + n_commit - nc0, 0);
    bus_start(); send_byte(dev(3, 0), a1); send_byte(8'h31, a2); send_byte(8'hC4, a3); bus_stop();
    chk(a3 && n_commit == nc0 + 1, "R6 lower half writable", a3, 1);
    wp = 1'b0;
    bus_start(); send_byte(dev(6, 0), a1); send_byte(8'h32, a2); send_byte(8'hC5, a3); bus_stop();
    chk(a3 && log_a[nb0 + 1] == 11'h632, "R6 upper writable after wp low", log_a[nb0 + 1], 'h632);
    chk(n_commit == nc0 + 2, "R6 commit after wp low", n_commit - nc0, 2);
  endtask

  task automatic t_read();
    bit a; logic [7:0] b0, b1; int nc0 = n_commit;
    bus_start(); send_byte(dev(5, 0), a); send_byte(8'hFF, a);
    bus_start(); send_byte(dev(5, 1), a);
    chk(a, "R7 read device ack", a, 1);
    recv_byte(1'b1, b0);
    recv_byte(1'b0, b1);
    bus_stop();
    chk(b0 == pat(11'h5FF), "R7 first read byte", b0, pat(11'h5FF));
    chk(b1 == pat(11'h600), "R7 read crosses block", b1, pat(11'h600));
    chk(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
    chk(n_commit == nc0, "R5 read no commit", n_commit - nc0, 0);
  endtask

  task automatic t_rstart_discard();
    bit a; int nc0 = n_commit;
    bus_start(); send_byte(dev(1, 0), a); send_byte(8'h50, a); send_byte(8'hEE, a);
    bus_start(); send_byte(dev(1, 0), a); bus_stop();
    chk(n_commit == nc0, "R5 repeated start discards", n_commit - nc0, 0);
  endtask

  task automatic t_abort();
    bit a; int nb0 = n_bytes;
    bus_start(); send_bits(dev(0, 0), 4); bus_stop();
    chk(sda_oe == 1'b0, "R8 idle after mid-byte stop", sda_oe, 0);
    bus_start(); send_bits(8'hFF, 3); bus_start();
    send_byte(dev(7, 0), a); chk(a, "R8 ack after mid-byte start", a, 1);
    send_byte(8'h09, a); send_byte(8'h3C, a); bus_stop();
    chk(n_bytes == nb0 + 1 && log_a[nb0] == 11'h709, "R8 write after abort", log_a[nb0], 'h709);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_byte_write();
    t_busy_poll();
    t_wrong_code();
    t_page();
    t_protect();
    t_read();
    t_rstart_discard();
    t_abort();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule